// File: doc/BRIEF.md
# Fractional baud-rate generator

This block turns the system clock into a periodic strobe at sixteen times a serial line's bit rate, plus a second strobe at the bit rate itself. The rate comes from a divisor with a 16-bit whole part and a 6-bit fraction counted in sixty-fourths of a clock. The divisor equals the clock frequency over sixteen times the wanted baud rate. Most 16x periods last the whole part in clocks. A 6-bit phase accumulator adds the fraction once per period, and each carry out of it lengthens that one period by a clock. Over any run of 64 periods the average is therefore exact, and no single period strays by more than one clock.

Software writes through a small write port. Writing the whole-part or fraction slot only stages a value. The running divisor stays as it is until the line-control slot is written. That write copies both staged values into the running divisor, latches the line-control byte and starts a fresh period with a cleared accumulator. A running whole part of 0 or 1 is not a usable setting, and the generator then stays silent. For example, with a 20 MHz clock a whole part of 10 and a fraction of 54 give one 16x strobe per 10 + 54/64 clocks on average, close to 115274 baud.

Top module: `frac_baud_gen`

## Requirements
- R1: After a synchronous active-high reset, line_ctrl reads 0 and no baud16_tick is issued until a valid divisor has been committed.
- R2: A write to the whole-part slot (wr_addr 0, value in wr_data[15:0]) or to the fraction slot (wr_addr 1, value in wr_data[5:0]) leaves the running rate and line_ctrl unchanged.
- R3: A write to the line-control slot (wr_addr 2) puts the staged whole part and fraction into effect and shows wr_data[7:0] on line_ctrl from the next cycle.
- R4: With whole part D and fraction F, every 16x period after the first lasts exactly D + c clocks. Here c is 1 when adding F to the 6-bit accumulator carries out, and 0 otherwise. So the j-th period ends span(j) = j*D + floor(j*F/64) clocks after the first strobe.
- R5: Any 64 consecutive 16x periods together last exactly 64*D + F clocks, whatever the starting phase.
- R6: After a commit, the first baud16_tick comes D-1 clock edges after the committing edge. The accumulator restarts from zero.
- R7: bit_tick is high only together with baud16_tick, on the 16th, 32nd, 48th and later strobes counted from the last commit.
- R8: While the running whole part is 0 or 1, baud16_tick and bit_tick stay low.
- R9: With a fraction of 0, every 16x period lasts exactly D clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Slot select: 0 whole part, 1 fraction, 2 line control |
| wr_data | input | 16 | Write data |
| baud16_tick | output | 1 | One-clock strobe at 16x the bit rate |
| bit_tick | output | 1 | One-clock strobe at the bit rate |
| line_ctrl | output | 8 | Line-control byte latched by the last commit |

## Verification
The hardest case to reach from the ports is a staged divisor write that lands while the generator runs at another rate. The old rate must carry on untouched until a later line-control write. The bench reaches this by staging new values in the middle of a running configuration. It measures periods before the commit, then commits with a lone line-control write and measures again. Exact timing against the carry pattern is checked by logging every strobe time after a commit. Each period is compared with the closed-form span, and random 64-period windows are compared with 64*D + F.

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int INT_W     = 16,
  parameter int FRAC_W    = 6,
  parameter int LC_W      = 8,
  parameter int OVS       = 16,
  parameter int AW        = 2,
  parameter int DW        = 16,
  parameter int ADDR_INT  = 0,
  parameter int ADDR_FRAC = 1,
  parameter int ADDR_LC   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic            baud16_tick,
  output logic            bit_tick,
  output logic [LC_W-1:0] line_ctrl
);
  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  logic [INT_W-1:0]  pend_int, act_int, cnt;
  logic [FRAC_W-1:0] pend_frac, act_frac, acc;
  logic [SUB_W-1:0]  sub;
  logic [FRAC_W:0]   acc_sum;
  logic              commit, valid;

  assign commit      = wr_en && (wr_addr == AW'(ADDR_LC));
  assign valid       = act_int > INT_W'(1);
  assign acc_sum     = {1'b0, acc} + {1'b0, act_frac};
  assign baud16_tick = valid && (cnt == '0);
  assign bit_tick    = baud16_tick && (sub == SUB_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_int  <= '0;
      pend_frac <= '0;
      act_int   <= '0;
      act_frac  <= '0;
      line_ctrl <= '0;
      cnt       <= '0;
      acc       <= '0;
      sub       <= '0;
    end else begin
      if (wr_en && wr_addr == AW'(ADDR_INT))  pend_int  <= wr_data[INT_W-1:0];
      if (wr_en && wr_addr == AW'(ADDR_FRAC)) pend_frac <= wr_data[FRAC_W-1:0];
      if (commit) begin
        act_int   <= pend_int;
        act_frac  <= pend_frac;
        line_ctrl <= wr_data[LC_W-1:0];
        cnt       <= pend_int - INT_W'(1);
        acc       <= '0;
        sub       <= '0;
      end else if (baud16_tick) begin
        acc <= acc_sum[FRAC_W-1:0];
        cnt <= act_int - INT_W'(1) + INT_W'(acc_sum[FRAC_W]);
        sub <= (sub == SUB_LAST) ? '0 : sub + SUB_W'(1);
      end else if (valid) begin
        cnt <= cnt - INT_W'(1);
      end
    end
  end
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
  parameter int INT_W   = 16,
  parameter int FRAC_W  = 6,
  parameter int LC_W    = 8,
  parameter int AW      = 2,
  parameter int DW      = 16,
  parameter int ADDR_LC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic              baud16_tick,
  input logic              bit_tick,
  input logic [LC_W-1:0]   line_ctrl,
  input logic [INT_W-1:0]  act_int,
  input logic [FRAC_W-1:0] act_frac
);
  logic [INT_W:0] gap;
  logic           commit;
  assign commit = wr_en && (wr_addr == AW'(ADDR_LC));

  always_ff @(posedge clk) begin
    if (rst)                        gap <= '0;
    else if (commit || baud16_tick) gap <= (INT_W+1)'(1);
    else if (gap != '1)             gap <= gap + (INT_W+1)'(1);
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!baud16_tick && line_ctrl == '0));

  p_stage_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != AW'(ADDR_LC)) |=>
      ($stable(act_int) && $stable(act_frac) && $stable(line_ctrl)));

  p_commit_lc_r3: assert property (@(posedge clk) disable iff (rst)
    commit |=> (line_ctrl == $past(wr_data[LC_W-1:0])));

  p_period_bound_r4: assert property (@(posedge clk) disable iff (rst)
    baud16_tick |-> (gap == {1'b0, act_int} || gap == {1'b0, act_int} + (INT_W+1)'(1)));

  p_bit_in_tick_r7: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> baud16_tick);

  p_invalid_silent_r8: assert property (@(posedge clk) disable iff (rst)
    (act_int < INT_W'(2)) |-> (!baud16_tick && !bit_tick));
endmodule

bind frac_baud_gen frac_baud_gen_chk #(
  .INT_W(INT_W), .FRAC_W(FRAC_W), .LC_W(LC_W), .AW(AW), .DW(DW), .ADDR_LC(ADDR_LC)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .baud16_tick(baud16_tick), .bit_tick(bit_tick), .line_ctrl(line_ctrl),
  .act_int(act_int), .act_frac(act_frac)
);

// File: tb/tb_frac_baud_gen.sv
module tb_frac_baud_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NLOG = 128;
  localparam int NT = 80;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  wire baud16_tick, bit_tick;
  wire [7:0] line_ctrl;

  frac_baud_gen dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .baud16_tick(baud16_tick), .bit_tick(bit_tick), .line_ctrl(line_ctrl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int ts [NLOG];
  bit bt [NLOG];
  int nt = 0, orphan = 0, c0 = 0;
  int checks = 0, fails = 0;

  always @(negedge clk) begin
    if (baud16_tick) begin
      if (nt < NLOG) begin ts[nt] = cyc; bt[nt] = bit_tick; end
      nt = nt + 1;
    end
    if (bit_tick && !baud16_tick) orphan = orphan + 1;
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int span(int di, int df, int j);
    return j * di + (j * df) / 64;
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 2'(a); wr_data = 16'(d);
    @(posedge clk); #1;
    wr_en = 0;
    if (a == 2) begin nt = 0; c0 = cyc; end
  endtask

  task automatic wait_ticks(int n);
    while (nt < n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic verify(int di, int df, int lc);
    int err, first_bad_a, first_bad_e, k, bterr;
    check(line_ctrl == 8'(lc), "R3", "line_ctrl after commit", line_ctrl, lc);
    wait_ticks(NT);
    check(ts[0] - c0 == di - 1, "R6", "first strobe delay", ts[0] - c0, di - 1);
    err = 0; first_bad_a = 0; first_bad_e = 0;
    for (int j = 1; j < NT; j++) begin
      if (ts[j] - ts[j-1] != span(di, df, j) - span(di, df, j-1)) begin
        if (err == 0) begin
          first_bad_a = ts[j] - ts[j-1];
          first_bad_e = span(di, df, j) - span(di, df, j-1);
        end
        err++;
      end
    end
    check(err == 0, "R4", "period length", first_bad_a, first_bad_e);
    check(ts[64] - ts[0] == 64*di + df, "R5", "64-period span", ts[64] - ts[0], 64*di + df);
    k = int'($urandom % 15) + 1;
    check(ts[k+64] - ts[k] == 64*di + df, "R5", "shifted 64-period span", ts[k+64] - ts[k], 64*di + df);
    bterr = 0;
    for (int j = 0; j < NT; j++) if (bt[j] != ((j % 16) == 15)) bterr++;
    check(bterr == 0, "R7", "bit strobe placement errors", bterr, 0);
    if (df == 0)
      check(ts[NT-1] - ts[0] == (NT-1)*di, "R9", "integer-only span", ts[NT-1] - ts[0], (NT-1)*di);
  endtask

  task automatic run_cfg(int di, int df, int lc);
    wr(0, di); wr(1, df); wr(2, lc);
    verify(di, df, lc);
  endtask

  task automatic run_invalid(int di, int lc);
    wr(0, di); wr(1, 17); wr(2, lc);
    repeat (200) @(posedge clk);
    @(negedge clk);
    check(nt == 0, "R8", "strobes with invalid whole part", nt, 0);
    check(line_ctrl == 8'(lc), "R3", "line_ctrl with invalid divisor", line_ctrl, lc);
  endtask

  initial begin
    int err;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    nt = 0;
    repeat (100) @(posedge clk);
    @(negedge clk);
    check(line_ctrl == 8'h00, "R1", "line_ctrl after reset", line_ctrl, 0);
    check(nt == 0, "R1", "strobes before commit", nt, 0);

    run_cfg(10, 54, 8'h76);
    run_cfg(2, 63, 8'h11);
    run_cfg(2, 0, 8'h22);
    run_cfg(3, 1, 8'h33);
    run_cfg(7, 32, 8'h44);
    run_invalid(1, 8'h55);
    run_invalid(0, 8'h66);

    run_cfg(12, 20, 8'h9A);
    wr(0, 5); wr(1, 3);
    nt = 0;
    wait_ticks(70);
    err = 0;
    for (int j = 1; j < 70; j++) if (ts[j] - ts[j-1] != 12 && ts[j] - ts[j-1] != 13) err++;
    check(err == 0, "R2", "periods after staging only", err, 0);
    check(ts[64] - ts[0] == 64*12 + 20, "R2", "span after staging only", ts[64] - ts[0], 64*12 + 20);
    check(line_ctrl == 8'h9A, "R2", "line_ctrl after staging only", line_ctrl, 8'h9A);
    wr(2, 8'hC3);
    verify(5, 3, 8'hC3);

    for (int i = 0; i < 8; i++) begin
      int di, df, lc;
      di = 2 + int'($urandom % 30);
      df = int'($urandom % 64);
      lc = int'($urandom % 256);
      run_cfg(di, df, lc);
    end

    check(orphan == 0, "R7", "bit strobes without 16x strobe", orphan, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule